// File: doc/BRIEF.md
# Clock Mode Transition Controller

This block sits in front of a microcontroller clock generator. It owns the control bits behind the system clock mode and decides which mode the chip runs in. The modes are high/medium speed, low speed, low power dissipation, PLL operation, on-chip oscillator, on-chip oscillator low power, stop and wait. Software-style write requests arrive one at a time as an operation code plus a small argument. They can pick the CPU clock source, start or stop the main and sub oscillators, set the CPU divide ratio, force divide-by-8, enable oscillation-stop detection, or enter stop or wait.

Each request is tested against a legality rule set before it takes effect. A refused request changes nothing and raises a one-cycle error pulse. Some accepted actions force the divide-by-8 setting as a side effect. A source switch is held pending until the target oscillator reports ready. The controller drives the oscillator enables, the source select code and the resulting CPU divide ratio. Stop and wait both end on an interrupt, which returns the chip to the mode it was in before entry.

Top module: `clkmode_ctrl`

## Requirements
- R1: With the divide-by-8 override at 0, `cpu_div` follows the ratio field set by op 0: arg 0 gives 1, arg 1 gives 2, arg 2 gives 4 and arg 3 gives 16.
- R2: With the override at 1 (op 1, arg[0]), `cpu_div` reads 8 whatever the ratio field holds. Ratio writes are still stored and show up once the override is cleared. The override is 1 after reset.
- R3: Selecting the PLL (op 5, arg[0]=1) is accepted only while the main clock is the source. While the PLL is the source, the only accepted source change is op 5 with arg[0]=0, which goes back to the main clock. Ops 4, 6 and 8 are refused while the PLL is the source.
- R4: Leaving stop mode on an interrupt sets the divide-by-8 override to 1.
- R5: Stopping the main oscillator (op 2, arg[0]=1) is accepted only while the sub clock or the on-chip oscillator is the source. When accepted, it also sets the divide-by-8 override.
- R6: Switching from the on-chip oscillator back to the main clock (op 6, arg[0]=0) is refused unless the override is already 1 and the main oscillator is running.
- R7: While the detection enable (op 7, arg[0]; read back on `det_en`) is 1, every mode-changing request is refused. The mode-changing requests are ops 2, 4, 5, 6, 8 and 9.
- R8: A request that selects the sub clock (op 4, arg[0]=1) or leaves it is accepted only while `sub_rdy` is 1. Selecting the sub clock also needs the sub oscillator enabled (op 3, arg[0]=1). Op 3 with arg[0]=0 is refused while the sub clock is the source.
- R9: Op 8 enters stop (mode 6), which drops every oscillator enable and `cpu_run`. Op 9 enters wait (mode 7), which drops only `cpu_run`. An `irq` in either returns to the earlier mode. Other requests are refused while stopped or waiting.
- R10: `clk_sel` encodes the source as 0 main, 1 PLL, 2 on-chip oscillator and 3 sub. `mode` encodes the modes as 0 high/medium, 1 low speed, 2 low power dissipation, 3 PLL, 4 on-chip oscillator, 5 on-chip oscillator low power, 6 stop and 7 wait. Modes 2 and 5 are modes 1 and 4 with the main oscillator stopped.
- R11: A refused request leaves every control bit unchanged and drives `err` high for exactly the cycle after it. Op codes 10 to 15 are always refused.
- R12: An accepted source switch raises `busy` and waits for the target's ready input. `clk_sel` changes on the clock edge where that ready is seen, and `mode` changes one cycle later. Requests that arrive while `busy` is high are refused.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe |
| req_op | input | 4 | Request operation code |
| req_arg | input | 2 | Request argument |
| irq | input | 1 | Interrupt that ends stop or wait |
| main_rdy | input | 1 | Main oscillator stable |
| sub_rdy | input | 1 | Sub oscillator oscillating |
| pll_rdy | input | 1 | PLL locked |
| oco_rdy | input | 1 | On-chip oscillator stable |
| mode | output | 3 | Current clock mode |
| clk_sel | output | 2 | CPU clock source select |
| cpu_div | output | 5 | CPU clock divide ratio |
| main_en | output | 1 | Main oscillator enable |
| sub_en | output | 1 | Sub oscillator enable |
| pll_en | output | 1 | PLL enable |
| oco_en | output | 1 | On-chip oscillator enable |
| cpu_run | output | 1 | CPU clock running |
| busy | output | 1 | Source switch pending |
| err | output | 1 | Request refused in previous cycle |
| det_en | output | 1 | Oscillation-stop detection enable |

## Verification
The assertion on `err` relies on two facts about the block. A refused request made while running can be followed, in that cycle, only by the completion of a pending switch. Nothing else may move the control bits. The assertions on the sub clock and the PLL check the ready input at the completion edge. They therefore take for granted that a ready input does not change between the accepting edge and the completing edge. The stimulus gives each request its own step, in which it holds every ready input constant and leaves idle cycles before the outputs are compared. The only exception is a directed case that holds `pll_rdy` low on purpose to hold a switch pending.

// File: rtl/clkmode_ctrl.sv
module clkmode_ctrl #(
  parameter int OPW  = 4,
  parameter int ARGW = 2,
  parameter int DIVW = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  input  logic [OPW-1:0]  req_op,
  input  logic [ARGW-1:0] req_arg,
  input  logic            irq,
  input  logic            main_rdy,
  input  logic            sub_rdy,
  input  logic            pll_rdy,
  input  logic            oco_rdy,
  output logic [2:0]      mode,
  output logic [1:0]      clk_sel,
  output logic [DIVW-1:0] cpu_div,
  output logic            main_en,
  output logic            sub_en,
  output logic            pll_en,
  output logic            oco_en,
  output logic            cpu_run,
  output logic            busy,
  output logic            err,
  output logic            det_en
);
  localparam logic [OPW-1:0] OP_RATIO = 0, OP_DIV8 = 1, OP_MSTOP = 2, OP_SUBOSC = 3,
                             OP_SELSUB = 4, OP_SELPLL = 5, OP_SELOCO = 6, OP_DETEN = 7,
                             OP_STOP = 8, OP_WAIT = 9;
  localparam logic [1:0] S_MAIN = 0, S_PLL = 1, S_OCO = 2, S_SUB = 3;
  localparam logic [1:0] L_RUN = 0, L_STOP = 1, L_WAIT = 2;
  localparam logic [2:0] M_HIGH = 0, M_LOW = 1, M_LPD = 2, M_PLL = 3,
                         M_OCO = 4, M_OCOLP = 5, M_STOP = 6, M_WAIT = 7;

  logic [1:0] src, ptgt, tgt, lp, ratio;
  logic       pend, main_stop, sub_on, div8, det_q, err_q;
  logic [2:0] mode_q, run_mode;
  logic       ok, sw, tgt_rdy;

  always_comb begin
    ok  = 1'b0;
    sw  = 1'b0;
    tgt = src;
    if (req_valid && !pend && lp == L_RUN) begin
      case (req_op)
        OP_RATIO, OP_DIV8, OP_DETEN: ok = 1'b1;
        OP_MSTOP:  ok = !det_q && (!req_arg[0] || src == S_SUB || src == S_OCO);
        OP_SUBOSC: ok = req_arg[0] || src != S_SUB;
        OP_SELSUB: begin
          sw = 1'b1;
          if (req_arg[0]) begin
            tgt = S_SUB;
            ok  = !det_q && (src == S_MAIN || src == S_OCO) && sub_on && sub_rdy;
          end else begin
            tgt = S_MAIN;
            ok  = !det_q && src == S_SUB && !main_stop && sub_rdy;
          end
        end
        OP_SELPLL: begin
          sw  = 1'b1;
          tgt = req_arg[0] ? S_PLL : S_MAIN;
          ok  = !det_q && (req_arg[0] ? src == S_MAIN : src == S_PLL);
        end
        OP_SELOCO: begin
          sw = 1'b1;
          if (req_arg[0]) begin
            tgt = S_OCO;
            ok  = !det_q && (src == S_MAIN || (src == S_SUB && sub_rdy));
          end else begin
            tgt = S_MAIN;
            ok  = !det_q && src == S_OCO && !main_stop && div8;
          end
        end
        OP_STOP: ok = !det_q && src != S_PLL;
        OP_WAIT: ok = !det_q;
        default: ok = 1'b0;
      endcase
    end
  end

  always_comb begin
    case (ptgt)
      S_MAIN:  tgt_rdy = main_rdy;
      S_PLL:   tgt_rdy = pll_rdy;
      S_OCO:   tgt_rdy = oco_rdy;
      default: tgt_rdy = sub_rdy;
    endcase
    if ((ptgt == S_SUB || src == S_SUB) && !sub_rdy) tgt_rdy = 1'b0;
  end

  always_comb begin
    case (src)
      S_MAIN:  run_mode = M_HIGH;
      S_PLL:   run_mode = M_PLL;
      S_OCO:   run_mode = main_stop ? M_OCOLP : M_OCO;
      default: run_mode = main_stop ? M_LPD : M_LOW;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      src       <= S_MAIN;
      ptgt      <= S_MAIN;
      pend      <= 1'b0;
      main_stop <= 1'b0;
      sub_on    <= 1'b0;
      div8      <= 1'b1;
      ratio     <= 2'b00;
      det_q     <= 1'b0;
      lp        <= L_RUN;
      err_q     <= 1'b0;
      mode_q    <= M_HIGH;
    end else begin
      err_q  <= req_valid && !ok;
      mode_q <= (lp == L_STOP) ? M_STOP : (lp == L_WAIT) ? M_WAIT : run_mode;
      if (pend && tgt_rdy) begin
        src  <= ptgt;
        pend <= 1'b0;
      end
      if (lp != L_RUN && irq) begin
        lp <= L_RUN;
        if (lp == L_STOP) div8 <= 1'b1;
      end
      if (ok) begin
        if (sw) begin
          ptgt <= tgt;
          pend <= 1'b1;
        end
        case (req_op)
          OP_RATIO:  ratio  <= req_arg;
          OP_DIV8:   div8   <= req_arg[0];
          OP_DETEN:  det_q  <= req_arg[0];
          OP_SUBOSC: sub_on <= req_arg[0];
          OP_MSTOP: begin
            main_stop <= req_arg[0];
            if (req_arg[0]) div8 <= 1'b1;
          end
          OP_STOP: lp <= L_STOP;
          OP_WAIT: lp <= L_WAIT;
          default: ;
        endcase
      end
    end
  end

  wire       stopped = (lp == L_STOP);
  wire [2:0] shamt   = (ratio == 2'b11) ? 3'd4 : {1'b0, ratio};

  assign cpu_div = div8 ? DIVW'(8) : (DIVW'(1) << shamt);
  assign mode    = mode_q;
  assign clk_sel = src;
  assign main_en = !main_stop && !stopped;
  assign sub_en  = sub_on && !stopped;
  assign pll_en  = (src == S_PLL || (pend && ptgt == S_PLL)) && !stopped;
  assign oco_en  = (src == S_OCO || (pend && ptgt == S_OCO)) && !stopped;
  assign cpu_run = (lp == L_RUN);
  assign busy    = pend;
  assign err     = err_q;
  assign det_en  = det_q;
endmodule

// File: rtl/clkmode_ctrl_chk.sv
module clkmode_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] clk_sel,
  input logic [2:0] mode,
  input logic [4:0] cpu_div,
  input logic       err,
  input logic       det_en,
  input logic       sub_en,
  input logic       sub_rdy,
  input logic       pll_rdy,
  input logic       main_stop_q,
  input logic       div8_q,
  input logic [1:0] lp_q
);
  a_r3_pll_entry: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_sel == 2'd1 && $past(clk_sel) != 2'd1) |-> $past(clk_sel) == 2'd0);

  a_r3_pll_exit: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(clk_sel) == 2'd1 && clk_sel != 2'd1) |-> clk_sel == 2'd0);

  a_r4_stop_exit: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(lp_q) == 2'd1 && lp_q != 2'd1) |-> div8_q);

  a_r5_mainstop_div8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(main_stop_q) |-> div8_q);

  a_r7_det_freeze: assert property (@(posedge clk) disable iff (!rst_n)
    $past(det_en) |-> ($stable(clk_sel) && $stable(main_stop_q) && $stable(lp_q)));

  a_r8_sub_ready: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(clk_sel) && (clk_sel == 2'd3 || $past(clk_sel) == 2'd3)) |-> $past(sub_rdy));

  a_r11_refuse_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (err && $past(lp_q) == 2'd0) |->
      ($stable(cpu_div) && $stable(det_en) && $stable(sub_en) && $stable(main_stop_q)));

  a_r12_pll_ready: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_sel == 2'd1 && $past(clk_sel) != 2'd1) |-> $past(pll_rdy));
endmodule

bind clkmode_ctrl clkmode_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .clk_sel(clk_sel), .mode(mode), .cpu_div(cpu_div),
  .err(err), .det_en(det_en), .sub_en(sub_en), .sub_rdy(sub_rdy), .pll_rdy(pll_rdy),
  .main_stop_q(main_stop), .div8_q(div8), .lp_q(lp)
);

// File: tb/sim_clkmode_ctrl.sv
module sim_clkmode_ctrl;
  logic clk = 0, rst_n = 0, req_valid = 0, irq = 0;
  logic [3:0] req_op = 0;
  logic [1:0] req_arg = 0;
  logic main_rdy = 1, sub_rdy = 1, pll_rdy = 1, oco_rdy = 1;
  logic [2:0] mode;
  logic [1:0] clk_sel;
  logic [4:0] cpu_div;
  logic main_en, sub_en, pll_en, oco_en, cpu_run, busy, err, det_en;

  clkmode_ctrl u0 (.*);

  always #4 clk = ~clk;

  int checks = 0, errors = 0;
  bit done = 0;

  int m_src = 0, m_lp = 0, m_ratio = 0;
  bit m_ms = 0, m_sub = 0, m_d8 = 1, m_det = 0;

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int exp_mode();
    if (m_lp == 1) return 6;
    if (m_lp == 2) return 7;
    case (m_src)
      0: return 0;
      1: return 3;
      2: return m_ms ? 5 : 4;
      default: return m_ms ? 2 : 1;
    endcase
  endfunction

  function automatic int exp_div();
    if (m_d8) return 8;
    case (m_ratio)
      0: return 1;
      1: return 2;
      2: return 4;
      default: return 16;
    endcase
  endfunction

  function automatic bit legal(int op, int arg);
    bit a = arg[0];
    int md = exp_mode();
    bit on_sub = (md == 1 || md == 2);
    bit on_oco = (md == 4 || md == 5);
    if (m_lp != 0) return 0;
    case (op)
      0, 1, 7: return 1;
      2: return !m_det && (!a || on_sub || on_oco);
      3: return a || !on_sub;
      4: return a ? (!m_det && (md == 0 || on_oco) && m_sub && sub_rdy)
                  : (!m_det && on_sub && !m_ms && sub_rdy);
      5: return !m_det && (a ? md == 0 : md == 3);
      6: return a ? (!m_det && (md == 0 || (on_sub && sub_rdy)))
                  : (!m_det && on_oco && !m_ms && m_d8);
      8: return !m_det && md != 3;
      9: return !m_det;
      default: return 0;
    endcase
  endfunction

  task automatic apply(int op, int arg);
    bit a = arg[0];
    case (op)
      0: m_ratio = arg;
      1: m_d8 = a;
      2: begin m_ms = a; if (a) m_d8 = 1; end
      3: m_sub = a;
      4: m_src = a ? 3 : 0;
      5: m_src = a ? 1 : 0;
      6: m_src = a ? 2 : 0;
      7: m_det = a;
      8: m_lp = 1;
      9: m_lp = 2;
      default: ;
    endcase
  endtask

  task automatic compare(string tag);
    bit stp = (m_lp == 1);
    check({tag, " R10 mode"}, mode, exp_mode());
    check({tag, " R10 clk_sel"}, clk_sel, m_src);
    check({tag, " R1 cpu_div"}, cpu_div, exp_div());
    check({tag, " R9 main_en"}, main_en, !m_ms && !stp);
    check({tag, " R9 sub_en"}, sub_en, m_sub && !stp);
    check({tag, " R9 pll_en"}, pll_en, m_src == 1 && !stp);
    check({tag, " R9 oco_en"}, oco_en, m_src == 2 && !stp);
    check({tag, " R9 cpu_run"}, cpu_run, m_lp == 0);
    check({tag, " R7 det_en"}, det_en, m_det);
    check({tag, " R12 busy"}, busy, 0);
  endtask

  task automatic do_req(string tag, int op, int arg);
    bit ok = legal(op, arg);
    @(negedge clk);
    req_valid = 1; req_op = 4'(op); req_arg = 2'(arg);
    @(negedge clk);
    req_valid = 0;
    check({tag, " R11 err"}, err, !ok);
    if (ok) apply(op, arg);
    repeat (3) @(negedge clk);
    check({tag, " R11 err clear"}, err, 0);
    compare(tag);
  endtask

  task automatic do_irq(string tag);
    @(negedge clk);
    irq = 1;
    @(negedge clk);
    irq = 0;
    if (m_lp == 1) m_d8 = 1;
    m_lp = 0;
    repeat (3) @(negedge clk);
    compare(tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=1 expected=0");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    compare("reset");
    check("reset R11 err", err, 0);

    do_req("R2 ratio ignored", 0, 3);
    check("R2 div stays 8", cpu_div, 8);
    do_req("R2 clear override", 1, 0);
    check("R1 code 11", cpu_div, 16);
    for (int r = 0; r < 3; r++) do_req("R1 ratio", 0, r);
    check("R1 code 10", cpu_div, 4);

    do_req("R8 sub off", 4, 1);
    do_req("R8 sub on", 3, 1);
    do_req("R8 to low", 4, 1);
    check("R8 low mode", mode, 1);
    do_req("R3 pll from low", 5, 1);
    do_req("R8 sub osc stop refused", 3, 0);
    do_req("R5 main stop", 2, 1);
    check("R5 lpd div8", cpu_div, 8);
    do_req("R5 main start", 2, 0);
    do_req("R8 back high", 4, 0);
    do_req("R5 stop from high", 2, 1);

    pll_rdy = 0;
    @(negedge clk);
    req_valid = 1; req_op = 5; req_arg = 1;
    @(negedge clk);
    req_valid = 0;
    check("R12 pll accepted", err, 0);
    repeat (3) @(negedge clk);
    check("R12 busy waiting", busy, 1);
    check("R12 sel held", clk_sel, 0);
    check("R12 pll_en on", pll_en, 1);
    req_valid = 1; req_op = 0; req_arg = 1;
    @(negedge clk);
    req_valid = 0;
    check("R12 refuse while busy", err, 1);
    pll_rdy = 1;
    @(negedge clk);
    check("R12 sel switched", clk_sel, 1);
    check("R12 mode lags", mode, 0);
    @(negedge clk);
    check("R12 mode pll", mode, 3);
    m_src = 1;
    compare("R12 settled");
    do_req("R3 oco from pll", 6, 1);
    do_req("R9 stop from pll", 8, 0);
    do_req("R3 pll to high", 5, 0);

    do_req("R6 to oco", 6, 1);
    do_req("R6 clear div8", 1, 0);
    do_req("R6 back refused", 6, 0);
    check("R6 still oco", mode, 4);
    do_req("R6 set div8", 1, 1);
    do_req("R6 back ok", 6, 0);

    do_req("R7 det on", 7, 1);
    do_req("R7 pll refused", 5, 1);
    do_req("R7 stop refused", 8, 0);
    do_req("R7 det off", 7, 0);

    do_req("R4 clear div8", 1, 0);
    do_req("R9 stop", 8, 0);
    check("R9 stop mode", mode, 6);
    do_req("R9 req in stop", 0, 2);
    do_irq("R4 stop exit");
    check("R4 div8 forced", cpu_div, 8);
    do_req("R9 clear div8", 1, 0);
    do_req("R9 wait", 9, 0);
    check("R9 wait main_en", main_en, 1);
    do_irq("R9 wait exit");
    check("R9 wait keeps div", cpu_div, exp_div());
    do_irq("R9 irq while running");
    do_req("R11 bad op", 12, 3);

    void'($urandom(32'h5eed));
    for (int i = 0; i < 600; i++) begin
      sub_rdy = ($urandom % 5) != 0;
      if (m_lp != 0 && ($urandom % 3) == 0) do_irq("rand irq");
      else begin
        int op = $urandom % 11;
        if (op == 7 && ($urandom % 2) == 0) do_req("rand det off", 7, 0);
        else do_req("rand", op, int'($urandom % 4));
      end
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule